// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer

This block converts a stream of dial symbols into loop-disconnect pulse trains on an active-low dial-pulse output at ten pulses per second. Each digit begins with a lead-in interval with the dial path muted. A counted series of break intervals follows, separated by make intervals. The digit ends with a fixed inter-digit gap. All timing is counted in ticks of an external 1 ms strobe, so the block holds no clock-frequency assumption.

A two-bit decoded mode selects one of three behaviours: tone dialing, or pulse dialing at 40:60 or 33:67 make:break. The mode is captured only while the dialer is idle. Two further symbols act as controls. A stored pause holds the line quiet for 3.6 s. A pulse-to-tone switch inserts the same pause and then routes every later symbol to an external tone generator until the hook input goes on-hook. A done flag tells the surrounding controller when the last gap or pause has run out.

Top module: `pulse_dialer`

## Requirements
- R1: While reset or on-hook, dp_n_o is 1, both mutes and done_o are 0, and sym_ready_o is 0. When off-hook and idle in pulse mode, sym_ready_o is 1.
- R2: Symbol codes 4'h1 to 4'h9 produce that many break intervals on dp_n_o, and code 4'h0 produces ten.
- R3: With ratio40_i = 1, each break lasts 60 ticks and each make between breaks lasts 40 ticks. With ratio40_i = 0, breaks last 67 ticks and makes last 33 ticks.
- R4: The first break of a digit is preceded by a lead-in of 40 ticks (ratio40_i = 1) or 33 ticks (ratio40_i = 0). During the lead-in dp_n_o is 1, and hs_mute_o and dial_mute_o are 1 from the cycle after acceptance.
- R5: After the last break, dp_n_o stays 1 for 800 ticks with both mutes 1. Then done_o rises and both mutes fall in the same cycle.
- R6: Code 4'hC holds dp_n_o at 1 for 3600 ticks with dial_mute_o at 1 and hs_mute_o at 0, and then raises done_o.
- R7: In pulse mode, code 4'hA runs the same 3600-tick hold and then latches tone mode. The latch stays set until off_hook_i goes low.
- R8: In pulse mode, code 4'hB and codes 4'hD to 4'hF are accepted but have no effect: dp_n_o, the mutes and done_o keep their values.
- R9: mode_tone_i and ratio40_i are sampled only while idle. A change during a digit does not alter that digit's timing.
- R10: In tone mode (mode_tone_i = 1 while idle, or the latch of R7 set), tone_valid_o equals sym_valid_i and tone_code_o equals sym_code_i. sym_ready_o follows tone_ready_i, and dp_n_o stays 1.
- R11: Timing advances only on cycles with tick_i = 1. Without ticks, the dialer holds its phase.
- R12: off_hook_i going low aborts any sequence. From the next cycle dp_n_o is 1, the mutes and done_o are 0, and the tone latch of R7 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per millisecond |
| off_hook_i | input | 1 | 1 = off-hook, 0 = on-hook |
| mode_tone_i | input | 1 | Decoded mode bit: tone dialing |
| ratio40_i | input | 1 | Decoded mode bit: 1 = 40:60, 0 = 33:67 |
| sym_valid_i | input | 1 | Symbol offered |
| sym_code_i | input | 4 | Symbol code (0-9 digits, A switch, B hash, C pause) |
| sym_ready_o | output | 1 | Symbol taken this cycle when valid |
| tone_ready_i | input | 1 | Tone generator can take a symbol |
| tone_valid_o | output | 1 | Symbol forwarded to the tone generator |
| tone_code_o | output | 4 | Forwarded symbol code |
| dp_n_o | output | 1 | Dial pulse, low during a break |
| hs_mute_o | output | 1 | Handset mute, high while a pulse digit is dialed |
| dial_mute_o | output | 1 | Dialing mute, high for any active sequence |
| done_o | output | 1 | Last gap or pause has expired |

## Verification
The hardest state to reach is the latched tone mode. It can only be entered by a completed 3.6 s hold after the switch symbol, and it can only be left through an on-hook event. The stimulus therefore runs the full hold and probes the tone route with the mode pins still reading pulse. It then drops and restores the hook before dialing a digit to prove the latch is gone. The same care applies to the idle-only mode sampling: the ratio pin is flipped one cycle after a digit is accepted, and the measured break and make widths must still match the old ratio.

// File: rtl/pd_pkg.sv
package pd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_BREAK,
      ST_MAKE,
      ST_GAP,
      ST_HOLD
   } pd_state_e;

   typedef enum logic [1:0] {
      SYM_DIGIT,
      SYM_PAUSE,
      SYM_SWITCH,
      SYM_NONE
   } pd_kind_e;

   localparam logic [3:0] CODE_SWITCH = 4'hA;
   localparam logic [3:0] CODE_PAUSE  = 4'hC;

   typedef struct packed {
      logic tone;
      logic ratio40;
   } pd_mode_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pd_symbol_decode.sv
module pd_symbol_decode
   import pd_pkg::*;
#(
   parameter int PCNT_W     = 4,
   parameter int ZERO_COUNT = 10
) (
   input  logic [3:0]        code_i,
   output pd_kind_e          kind_o,
   output logic [PCNT_W-1:0] pulses_o
);

   localparam int NCODES = 16;

   initial begin
      assert (ZERO_COUNT < (1 << PCNT_W))
         else $error("pd_symbol_decode: PCNT_W too narrow for ZERO_COUNT");
   end

   logic [PCNT_W-1:0] count_tab [NCODES];

   for (genvar g = 0; g < NCODES; g++) begin : g_tab
      if (g == 0) begin : g_zero
         assign count_tab[g] = PCNT_W'(ZERO_COUNT);
      end else if (g < 10) begin : g_num
         assign count_tab[g] = PCNT_W'(g);
      end else begin : g_ctl
         assign count_tab[g] = '0;
      end
   end

   assign pulses_o = count_tab[code_i];

   always_comb begin
      if (code_i < 4'd10)             kind_o = SYM_DIGIT;
      else if (code_i == CODE_PAUSE)  kind_o = SYM_PAUSE;
      else if (code_i == CODE_SWITCH) kind_o = SYM_SWITCH;
      else                            kind_o = SYM_NONE;
   end

endmodule

// File: rtl/pd_mode_latch.sv
module pd_mode_latch
   import pd_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     sample_en_i,
   input  logic     clear_i,
   input  logic     set_tone_i,
   input  logic     mode_tone_i,
   input  logic     ratio40_i,
   output pd_mode_t cfg_o,
   output logic     tone_lat_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_o <= '{tone: 1'b0, ratio40: 1'b1};
      end else if (sample_en_i) begin
         cfg_o <= '{tone: mode_tone_i, ratio40: ratio40_i};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         tone_lat_o <= 1'b0;
      else if (clear_i)    tone_lat_o <= 1'b0;
      else if (set_tone_i) tone_lat_o <= 1'b1;
   end

endmodule

// File: rtl/pd_tick_timer.sv
module pd_tick_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expire_o
);

   initial begin
      assert (CNT_W >= 2) else $error("pd_tick_timer: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cnt_q <= '0;
      else if (load_i)                  cnt_q <= load_val_i;
      else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = tick_i && (cnt_q == CNT_W'(1));

   AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) !$past(load_i) && !$past(tick_i) |-> $stable(cnt_q)); // R11

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
   import pd_pkg::*;
#(
   parameter int T_BREAK_FAST = 60,
   parameter int T_MAKE_FAST  = 40,
   parameter int T_LEAD_FAST  = 40,
   parameter int T_BREAK_SLOW = 67,
   parameter int T_MAKE_SLOW  = 33,
   parameter int T_LEAD_SLOW  = 33,
   parameter int T_PERIOD     = 100,
   parameter int T_GAP        = 800,
   parameter int T_HOLD       = 3600,
   parameter int ZERO_COUNT   = 10
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       off_hook_i,
   input  logic       mode_tone_i,
   input  logic       ratio40_i,
   input  logic       sym_valid_i,
   input  logic [3:0] sym_code_i,
   output logic       sym_ready_o,
   input  logic       tone_ready_i,
   output logic       tone_valid_o,
   output logic [3:0] tone_code_o,
   output logic       dp_n_o,
   output logic       hs_mute_o,
   output logic       dial_mute_o,
   output logic       done_o
);

   localparam int T_MAX  = imax(imax(T_HOLD, T_GAP), imax(T_BREAK_SLOW, T_BREAK_FAST));
   localparam int CNT_W  = $clog2(T_MAX + 1);
   localparam int PCNT_W = $clog2(ZERO_COUNT + 1);

   initial begin
      assert (T_BREAK_FAST + T_MAKE_FAST == T_PERIOD)
         else $error("pulse_dialer: fast ratio does not fill the pulse period");
      assert (T_BREAK_SLOW + T_MAKE_SLOW == T_PERIOD)
         else $error("pulse_dialer: slow ratio does not fill the pulse period");
      assert (T_LEAD_FAST > 0 && T_LEAD_SLOW > 0 && T_GAP > 0 && T_HOLD > 0)
         else $error("pulse_dialer: every interval must last at least one tick");
      assert (ZERO_COUNT >= 1) else $error("pulse_dialer: ZERO_COUNT must be positive");
   end

   pd_state_e         st_q, st_d;
   pd_kind_e          kind;
   pd_mode_t          cfg;
   logic [PCNT_W-1:0] dec_pulses;
   logic [PCNT_W-1:0] left_q;
   logic              tone_lat;
   logic              idle, tone_eff, take;
   logic              expire, tmr_load, set_tone;
   logic [CNT_W-1:0]  tmr_val;
   logic [CNT_W-1:0]  t_break, t_make, t_lead;
   logic              done_q;

   pd_symbol_decode #(
      .PCNT_W     (PCNT_W),
      .ZERO_COUNT (ZERO_COUNT)
   ) u_decode (
      .code_i   (sym_code_i),
      .kind_o   (kind),
      .pulses_o (dec_pulses)
   );

   pd_mode_latch u_mode (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sample_en_i (idle && !take),
      .clear_i     (!off_hook_i),
      .set_tone_i  (set_tone),
      .mode_tone_i (mode_tone_i),
      .ratio40_i   (ratio40_i),
      .cfg_o       (cfg),
      .tone_lat_o  (tone_lat)
   );

   pd_tick_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expire_o   (expire)
   );

   // Interval lengths follow the captured ratio, never the live pin.
   assign t_break = cfg.ratio40 ? CNT_W'(T_BREAK_FAST) : CNT_W'(T_BREAK_SLOW);
   assign t_make  = cfg.ratio40 ? CNT_W'(T_MAKE_FAST)  : CNT_W'(T_MAKE_SLOW);
   assign t_lead  = cfg.ratio40 ? CNT_W'(T_LEAD_FAST)  : CNT_W'(T_LEAD_SLOW);

   assign idle     = (st_q == ST_IDLE);
   assign tone_eff = cfg.tone || tone_lat;
   assign take     = sym_valid_i && off_hook_i && idle && !tone_eff;

   assign sym_ready_o  = off_hook_i && idle && (tone_eff ? tone_ready_i : 1'b1);
   assign tone_valid_o = off_hook_i && idle && tone_eff && sym_valid_i;
   assign tone_code_o  = sym_code_i;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      set_tone = 1'b0;
      if (!off_hook_i) begin
         st_d     = ST_IDLE;
         tmr_load = 1'b1;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (take) begin
                  unique case (kind)
                     SYM_DIGIT: begin
                        st_d     = ST_LEAD;
                        tmr_load = 1'b1;
                        tmr_val  = t_lead;
                     end
                     SYM_PAUSE: begin
                        st_d     = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_HOLD);
                     end
                     SYM_SWITCH: begin
                        st_d     = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_HOLD);
                        set_tone = 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
            ST_LEAD: begin
               if (expire) begin
                  st_d     = ST_BREAK;
                  tmr_load = 1'b1;
                  tmr_val  = t_break;
               end
            end
            ST_BREAK: begin
               if (expire) begin
                  tmr_load = 1'b1;
                  if (left_q == PCNT_W'(1)) begin
                     st_d    = ST_GAP;
                     tmr_val = CNT_W'(T_GAP);
                  end else begin
                     st_d    = ST_MAKE;
                     tmr_val = t_make;
                  end
               end
            end
            ST_MAKE: begin
               if (expire) begin
                  st_d     = ST_BREAK;
                  tmr_load = 1'b1;
                  tmr_val  = t_break;
               end
            end
            ST_GAP, ST_HOLD: begin
               if (expire) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_IDLE;
      else         st_q <= st_d;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     left_q <= '0;
      else if (!off_hook_i)                            left_q <= '0;
      else if (take && kind == SYM_DIGIT)              left_q <= dec_pulses;
      else if (st_q == ST_BREAK && expire)             left_q <= left_q - 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         done_q <= 1'b0;
      else if (!off_hook_i)                                done_q <= 1'b0;
      else if (take && kind != SYM_NONE)                   done_q <= 1'b0;
      else if ((st_q == ST_GAP || st_q == ST_HOLD) && expire) done_q <= 1'b1;
   end

   assign dp_n_o      = (st_q != ST_BREAK);
   assign hs_mute_o   = (st_q == ST_LEAD) || (st_q == ST_BREAK) ||
                        (st_q == ST_MAKE) || (st_q == ST_GAP);
   assign dial_mute_o = !idle;
   assign done_o      = done_q;

   // Checker state: ticks spent in the current break.
   logic [CNT_W-1:0] chk_brk_ticks;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chk_brk_ticks <= '0;
      else if (dp_n_o) chk_brk_ticks <= '0;
      else if (tick_i) chk_brk_ticks <= chk_brk_ticks + 1'b1;
   end

   AST_BREAK_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(dp_n_o) && $past(off_hook_i) |-> $past(chk_brk_ticks) == (cfg.ratio40 ? CNT_W'(T_BREAK_FAST - 1) : CNT_W'(T_BREAK_SLOW - 1))); // R3
   AST_BREAK_HAS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni) (st_q == ST_BREAK) |-> (left_q != '0)); // R2
   AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni) (st_q != ST_IDLE) |-> $stable(cfg)); // R9
   AST_ONHOOK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !off_hook_i |=> dp_n_o && !dial_mute_o && !hs_mute_o && !done_o && !tone_lat); // R12
   AST_TONE_NO_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni) tone_lat |-> dp_n_o && !hs_mute_o); // R7
   AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> !dial_mute_o); // R5
   AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) off_hook_i && !tick_i && (st_q != ST_IDLE) |=> $stable(st_q)); // R11
   AST_ONE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni) tone_valid_o |-> dp_n_o && !dial_mute_o); // R10

endmodule

// File: tb/pulse_dialer_bench.sv
module pulse_dialer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n, tick, off_hook, mode_tone, ratio40;
   logic       sym_valid, tone_ready;
   logic [3:0] sym_code;
   logic       sym_ready, tone_valid, dp_n, hs_mute, dial_mute, done;
   logic [3:0] tone_code;

   int  tests  = 0;
   int  failed = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pulse_dialer u_pulse_dialer (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .tick_i       (tick),
      .off_hook_i   (off_hook),
      .mode_tone_i  (mode_tone),
      .ratio40_i    (ratio40),
      .sym_valid_i  (sym_valid),
      .sym_code_i   (sym_code),
      .sym_ready_o  (sym_ready),
      .tone_ready_i (tone_ready),
      .tone_valid_o (tone_valid),
      .tone_code_o  (tone_code),
      .dp_n_o       (dp_n),
      .hs_mute_o    (hs_mute),
      .dial_mute_o  (dial_mute),
      .done_o       (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] code);
      @(negedge clk);
      sym_code  = code;
      sym_valid = 1'b1;
      check(sym_ready == 1'b1, "R1", "ready when idle off-hook", sym_ready, 1);
      @(negedge clk);
      sym_valid = 1'b0;
   endtask

   task automatic dial_digit(input logic [3:0] code, input bit flip);
      int  n_exp, b_exp, m_exp, p_exp;
      int  nlow, runlen, bad_b, bad_m, mute_bad, p_act, cyc;
      bit  prev, first;
      string rq;
      n_exp = (code == 4'd0) ? 10 : int'(code);
      b_exp = ratio40 ? 60 : 67;
      m_exp = 100 - b_exp;
      p_exp = ratio40 ? 40 : 33;
      rq    = flip ? "R9" : "R3";
      nlow = 0; runlen = 0; bad_b = 0; bad_m = 0; mute_bad = 0; p_act = -1; cyc = 0;
      prev = 1'b1; first = 1'b1;
      send(code);
      if (flip) ratio40 = !ratio40;
      while (!done && cyc < 20000) begin
         if (!hs_mute || !dial_mute) mute_bad++;
         if (dp_n != prev) begin
            if (prev) begin
               if (first) p_act = runlen;
               else if (runlen != m_exp) bad_m++;
               first = 1'b0;
            end else begin
               if (runlen != b_exp) bad_b++;
               nlow++;
            end
            runlen = 0;
            prev   = dp_n;
         end
         runlen++;
         cyc++;
         @(negedge clk);
      end
      if (flip) ratio40 = !ratio40;
      check(nlow == n_exp, "R2", $sformatf("break count for code %0d", code), nlow, n_exp);
      check(bad_b == 0, rq, $sformatf("mismatched breaks, code %0d", code), bad_b, 0);
      check(bad_m == 0, rq, $sformatf("mismatched makes, code %0d", code), bad_m, 0);
      check(p_act == p_exp, "R4", "lead-in length", p_act, p_exp);
      check(mute_bad == 0, "R4", "mutes low during digit", mute_bad, 0);
      check(prev == 1'b1 && runlen == 800, "R5", "inter-digit gap", runlen, 800);
      check(done && !hs_mute && !dial_mute, "R5", "done with mutes released",
            {done, hs_mute, dial_mute}, 3'b100);
   endtask

   task automatic measure_hold(input string req);
      int len, bad;
      len = 0; bad = 0;
      while (!done && len < 10000) begin
         if (!dp_n || !dial_mute || hs_mute) bad++;
         len++;
         @(negedge clk);
      end
      check(len == 3600, req, "hold length", len, 3600);
      check(bad == 0, req, "hold outputs (dp high, dial mute only)", bad, 0);
   endtask

   task automatic probe_tone(input logic [3:0] code, input string req);
      int bad;
      bad = 0;
      @(negedge clk);
      tone_ready = 1'b0;
      sym_code   = code;
      sym_valid  = 1'b1;
      #1;
      check(tone_valid && tone_code == code, req, "tone forward", {tone_valid, tone_code}, {1'b1, code});
      check(!sym_ready, req, "ready follows tone_ready=0", sym_ready, 0);
      tone_ready = 1'b1;
      #1;
      check(sym_ready, req, "ready follows tone_ready=1", sym_ready, 1);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (!dp_n || dial_mute || hs_mute) bad++;
      end
      check(bad == 0, req, "no pulse activity in tone mode", bad, 0);
      sym_valid  = 1'b0;
      tone_ready = 1'b0;
   endtask

   initial begin
      int bad, lows, cyc;
      bit done_before;
      rst_n = 1'b0; tick = 1'b1; off_hook = 1'b0; mode_tone = 1'b0; ratio40 = 1'b1;
      sym_valid = 1'b0; sym_code = 4'd0; tone_ready = 1'b0;
      repeat (3) @(negedge clk);
      check(dp_n && !hs_mute && !dial_mute && !done, "R1", "reset outputs",
            {dp_n, hs_mute, dial_mute, done}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      sym_valid = 1'b1;
      #1;
      check(!sym_ready && !tone_valid, "R1", "on-hook refuses symbols", sym_ready, 0);
      sym_valid = 1'b0;
      off_hook = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R4 R5: full digit sweep, both ratios
      ratio40 = 1'b1;
      repeat (2) @(negedge clk);
      for (int d = 0; d < 10; d++) dial_digit(4'(d), 1'b0);
      ratio40 = 1'b0;
      repeat (2) @(negedge clk);
      for (int d = 0; d < 10; d++) dial_digit(4'(d), 1'b0);

      // R9: ratio pin flipped mid-digit
      ratio40 = 1'b1;
      repeat (2) @(negedge clk);
      dial_digit(4'd7, 1'b1);
      ratio40 = 1'b0;
      repeat (2) @(negedge clk);
      dial_digit(4'd2, 1'b1);

      // R8: ignored symbols
      for (int c = 11; c < 16; c++) begin
         if (c == 12) continue;
         done_before = done;
         send(4'(c));
         bad = 0;
         for (int i = 0; i < 100; i++) begin
            if (!dp_n || hs_mute || dial_mute || done != done_before) bad++;
            @(negedge clk);
         end
         check(bad == 0, "R8", $sformatf("code %0d has no effect", c), bad, 0);
      end

      // R6: stored pause
      send(4'hC);
      measure_hold("R6");
      check(done, "R6", "done after pause", done, 1);

      // R11: no ticks, no progress
      tick = 1'b0;
      send(4'd1);
      bad = 0;
      for (int i = 0; i < 150; i++) begin
         if (!dp_n || !dial_mute || done) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R11", "frozen without ticks", bad, 0);
      tick = 1'b1;
      lows = 0; cyc = 0;
      while (!done && cyc < 5000) begin
         if (!dp_n) lows++;
         cyc++;
         @(negedge clk);
      end
      check(lows == 67, "R11", "break ticks after resume", lows, 67);

      // R12: abort mid-digit
      send(4'd3);
      repeat (120) @(negedge clk);
      off_hook = 1'b0;
      @(negedge clk);
      check(dp_n && !hs_mute && !dial_mute && !done && !sym_ready, "R12", "abort outputs",
            {dp_n, hs_mute, dial_mute, done, sym_ready}, 5'b10000);
      off_hook = 1'b1;
      repeat (2) @(negedge clk);

      // R7: switch symbol, hold, then tone route with pins still in pulse mode
      send(4'hA);
      measure_hold("R7");
      probe_tone(4'd5, "R7");

      // R12: on-hook clears the tone latch
      off_hook = 1'b0;
      repeat (3) @(negedge clk);
      off_hook = 1'b1;
      repeat (2) @(negedge clk);
      dial_digit(4'd4, 1'b0);

      // R10: tone mode from the pins
      mode_tone = 1'b1;
      repeat (2) @(negedge clk);
      probe_tone(4'd9, "R10");
      mode_tone = 1'b0;
      repeat (2) @(negedge clk);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         tests++;
         failed++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
         $display("[TB] %0d tests run, %0d failed", tests, failed);
         $finish;
      end
   end

endmodule